// File: doc/BRIEF.md
# Rotating Nibble Board Identification Port

This block answers reads of a board's 8-bit identification port. The 16-bit signature is too wide for the port, so each read returns one 4-bit slice of it in the upper half of the byte. The two lowest bits of the same byte carry the index of that slice. After each read the block moves on to the next slice. A host performs four reads, shifts each slice left by four times its index, and ORs the results. This rebuilds the whole signature no matter which slice the first read happened to hit.

Three things drive the block: a read strobe from the bus decoder, a board reset level taken from the adapter's control register, and the synchronous system reset. A slice only counts as consumed when its read completes, that is, when the strobe falls. A read whose strobe rose while the board reset was held is never counted. Another register shares this port address for writes, but write cycles never reach this block, so they cannot move its position.

Top module: `auto_id_port`

## Requirements
- R1: Bits 7:4 of `rd_data` hold signature slice k, where slice k is `SIGNATURE[4k+3:4k]`. With the default 16'hBABA, slices 0..3 are A, B, A, B.
- R2: Bits 1:0 of `rd_data` give the current slice index k (0..3). Bits 3:2 are always 0.
- R3: The slice index advances by one on the clock edge that samples `rd_strobe` low after it was sampled high, provided the strobe's rising edge was seen while `asic_reset` was low. The index does not change while the strobe stays high.
- R4: Four consecutive completed reads return four distinct indices, whatever the starting index. ORing (slice << 4*index) over them gives exactly `SIGNATURE`.
- R5: While `rst` is high, the index is cleared to 0 on the next clock edge.
- R6: While `asic_reset` is high, `rd_data` shows index 0 with slice 0, and the stored index is cleared to 0. Strobe pulses during this time do not advance it.
- R7: A read whose strobe rose while `asic_reset` was high, and which ends after `asic_reset` falls, does not advance the index. This also holds when the strobe falls in the same cycle that `asic_reset` falls.
- R8: From index 3 a completed read wraps the index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| asic_reset | input | 1 | Board reset level from the adapter control bit; high holds the ID logic at index 0 |
| rd_strobe | input | 1 | Read strobe for the ID port address, high during a read |
| rd_data | output | 8 | Returned byte: slice in 7:4, zeros in 3:2, index in 1:0 |

## Verification
Two events can land in the same clock: the board reset being released, and a read strobe falling. The bench provokes this overlap in two ways. First, it raises the strobe while the reset is held and drops both in the same cycle. Second, it keeps the strobe high across the release and drops it a few cycles later. In both cases the byte seen afterwards must still show index 0. Separately, the bench raises the board reset in the middle of a read that began normally and checks that the strobe's fall does not advance the index.

// File: rtl/auto_id_pkg.sv
package auto_id_pkg;

    localparam int SIG_W   = 16;
    localparam int SLICE_W = 4;
    localparam int SLICES  = SIG_W / SLICE_W;
    localparam int IDX_W   = $clog2(SLICES);
    localparam int BYTE_W  = 8;
    localparam int PAD_W   = BYTE_W - SLICE_W - IDX_W;

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic [SLICE_W-1:0] slice;
        logic [PAD_W-1:0]   pad;
        idx_t               idx;
    } id_byte_t;

    function automatic logic [SLICE_W-1:0] slice_of(input logic [SIG_W-1:0] sig,
                                                     input idx_t k);
        return sig[k*SLICE_W +: SLICE_W];
    endfunction

    function automatic idx_t next_idx(input idx_t k);
        if (k == idx_t'(SLICES - 1)) return '0;
        return k + idx_t'(1);
    endfunction

endpackage

// File: rtl/aip_strobe_track.sv
module aip_strobe_track (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic strobe,
    output logic done
);
    logic prev_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q <= strobe;
            if (hold)
                armed_q <= 1'b0;
            else if (strobe && !prev_q)
                armed_q <= 1'b1;
            else if (!strobe)
                armed_q <= 1'b0;
        end
    end

    assign done = armed_q && !strobe && !hold;
endmodule

// File: rtl/aip_pos_counter.sv
module aip_pos_counter
    import auto_id_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output idx_t pos
);
    idx_t pos_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            pos_q <= '0;
        else if (step)
            pos_q <= next_idx(pos_q);
    end

    assign pos = pos_q;
endmodule

// File: rtl/aip_formatter.sv
module aip_formatter
    import auto_id_pkg::*;
#(
    parameter logic [SIG_W-1:0] SIGNATURE = 16'hBABA
) (
    input  idx_t              pos,
    input  logic              hold,
    output logic [BYTE_W-1:0] data
);
    idx_t     shown;
    id_byte_t b;

    always_comb begin
        shown   = hold ? idx_t'(0) : pos;
        b.slice = slice_of(SIGNATURE, shown);
        b.pad   = '0;
        b.idx   = shown;
    end

    assign data = b;
endmodule

// File: rtl/auto_id_port.sv
module auto_id_port
    import auto_id_pkg::*;
#(
    parameter logic [15:0] SIGNATURE = 16'hBABA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       asic_reset,
    input  logic       rd_strobe,
    output logic [7:0] rd_data
);
    logic read_done;
    idx_t pos_q;

    aip_strobe_track u_trk (
        .clk    (clk),
        .rst    (rst),
        .hold   (asic_reset),
        .strobe (rd_strobe),
        .done   (read_done)
    );

    aip_pos_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (asic_reset),
        .step (read_done),
        .pos  (pos_q)
    );

    aip_formatter #(.SIGNATURE(SIGNATURE)) u_fmt (
        .pos  (pos_q),
        .hold (asic_reset),
        .data (rd_data)
    );
endmodule

// File: rtl/aip_checker.sv
module aip_checker #(
    parameter logic [15:0] SIG = 16'hBABA
) (
    input logic       clk,
    input logic       rst,
    input logic       asic_reset,
    input logic       rd_strobe,
    input logic [7:0] rd_data,
    input logic [1:0] pos
);
    a_r1_slice: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:4] == SIG[rd_data[1:0]*4 +: 4]);

    a_r2_index: assert property (@(posedge clk) disable iff (rst)
        !asic_reset |-> rd_data[1:0] == pos);

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!asic_reset && !$fell(rd_strobe)) |=> $stable(pos));

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pos == $past(pos) || pos == $past(pos) + 2'd1 || pos == 2'd0));

    a_r5_clear: assert property (@(posedge clk)
        rst |=> pos == 2'd0);

    a_r6_show0: assert property (@(posedge clk) disable iff (rst)
        asic_reset |-> rd_data[1:0] == 2'd0);

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        asic_reset |=> pos == 2'd0);
endmodule

bind auto_id_port aip_checker #(.SIG(SIGNATURE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .asic_reset (asic_reset),
    .rd_strobe  (rd_strobe),
    .rd_data    (rd_data),
    .pos        (pos_q)
);

// File: tb/sim_auto_id_port.sv
module sim_auto_id_port;
    localparam logic [15:0] SIG = 16'hBABA;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       asic_reset = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    auto_id_port #(.SIGNATURE(SIG)) u0 (
        .clk(clk), .rst(rst), .asic_reset(asic_reset),
        .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_byte(input logic [1:0] k);
        return {SIG[k*4 +: 4], 2'b00, k};
    endfunction

    task automatic check_byte(input string req, input logic [1:0] k);
        checks++;
        if (rd_data !== exp_byte(k)) begin
            errors++;
            $display("FAIL %s rd_data actual %h expected %h", req, rd_data, exp_byte(k));
        end
    endtask

    task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // full read: byte sampled during strobe, advance visible one negedge after fall
    task automatic do_read(output logic [7:0] got);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) got = rd_data;
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_asic();
        @(negedge clk) asic_reset = 1'b1;
        @(negedge clk) asic_reset = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_byte("R5 reset state", 2'd0);
    endtask

    task automatic t_sequence();
        logic [7:0] g;
        for (int i = 0; i < 6; i++) begin
            do_read(g);
            check_val("R1 R2 read byte", {8'h0, g}, {8'h0, exp_byte(2'(i))});
            check_byte("R3 R8 advanced index", 2'(i + 1));
        end
    endtask

    task automatic t_hold();
        pulse_asic();
        @(negedge clk) rd_strobe = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check_byte("R3 no advance while strobe high", 2'd0);
        end
        rd_strobe = 1'b0;
        @(negedge clk);
        check_byte("R3 advance on fall", 2'd1);
    endtask

    task automatic t_phase();
        logic [7:0] g;
        for (int s = 0; s < 4; s++) begin
            logic [15:0] acc;
            logic [3:0]  seen;
            pulse_asic();
            for (int j = 0; j < s; j++) do_read(g);
            acc = '0;
            seen = '0;
            for (int j = 0; j < 4; j++) begin
                do_read(g);
                acc = acc | (16'(g[7:4]) << (4 * g[1:0]));
                seen[g[1:0]] = 1'b1;
            end
            check_val("R4 rebuilt signature", acc, SIG);
            check_val("R4 all indices seen", {12'h0, seen}, 16'h000F);
        end
    endtask

    task automatic t_asic();
        logic [7:0] g;
        pulse_asic();
        do_read(g);
        do_read(g);
        check_byte("R6 before board reset", 2'd2);
        @(negedge clk) asic_reset = 1'b1;
        @(negedge clk);
        check_byte("R6 shown index during reset", 2'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) rd_strobe = 1'b1;
            @(negedge clk) rd_strobe = 1'b0;
        end
        @(negedge clk) asic_reset = 1'b0;
        @(negedge clk);
        check_byte("R6 index after release", 2'd0);
        // read began normally, board reset raised mid-read
        do_read(g);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) asic_reset = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk) asic_reset = 1'b0;
        @(negedge clk);
        check_byte("R6 reset mid read clears", 2'd0);
    endtask

    task automatic t_straddle();
        logic [7:0] g;
        pulse_asic();
        do_read(g);
        // strobe rises in reset, falls in the release cycle
        @(negedge clk) begin asic_reset = 1'b1; rd_strobe = 1'b1; end
        @(negedge clk);
        @(negedge clk) begin asic_reset = 1'b0; rd_strobe = 1'b0; end
        @(negedge clk);
        check_byte("R7 same-cycle release and fall", 2'd0);
        // strobe held across release, falls later
        @(negedge clk) begin asic_reset = 1'b1; rd_strobe = 1'b1; end
        @(negedge clk) asic_reset = 1'b0;
        repeat (3) @(negedge clk);
        check_byte("R7 straddling read in progress", 2'd0);
        rd_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_byte("R7 straddling read not counted", 2'd0);
        do_read(g);
        check_byte("R7 next read counts", 2'd1);
    endtask

    task automatic t_sysreset();
        logic [7:0] g;
        do_read(g);
        do_read(g);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check_byte("R5 system reset clears index", 2'd0);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_hold();
        t_phase();
        t_asic();
        t_straddle();
        t_sysreset();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule